// File: doc/BRIEF.md
# Strapped-Address I2C Register Target

This block is a target on a two-wire I2C bus that gives a host controller byte access to an 8-bit register file elsewhere in the device. A two-bit strap input selects one of four consecutive 7-bit bus addresses, so up to four copies of the device can share one bus. SCL is only ever observed. SDA is observed and can also be pulled low through an open-drain enable. Both lines are sampled with the block's own system clock through synchronisers. START and STOP are recognised as SDA edges that occur while SCL is high.

A write transaction carries the device address with R/W low, then a byte that loads the internal register pointer, then any number of data bytes. Each data byte is written through a one-cycle write strobe at the pointer, and the pointer then advances. A read transaction, usually reached through a repeated START, returns bytes from the pointer, MSB first. The read continues while the host acknowledges each byte and stops when the host does not. A data write of the key value 0x63 to register 0x80 also raises a single-cycle soft-reset pulse. This pulse is meant for the rest of the device and never touches this interface's own state.

Top module: `strap_i2c_target`

## Requirements
- R1: The strap selects the device address as base 0x5A plus the strap value: 2'b00 (ground) gives 0x5A, 2'b01 (supply) gives 0x5B, 2'b10 (tied to SDA) gives 0x5C, 2'b11 (tied to SCL) gives 0x5D.
- R2: When the address byte names any other address, the block does not acknowledge it. Until the next START it does not drive SDA and issues no register write.
- R3: The block acknowledges a matching address byte and every byte written to it. It does this by pulling SDA low (sda_oe = 1) for the ninth SCL clock. sda_oe changes only in response to an SCL falling edge, a START or a STOP.
- R4: In a write, the first byte after the address loads the register pointer (reg_addr). Each later byte produces a one-cycle reg_we with reg_wdata at the pointer, and the pointer then advances by one, wrapping from 0xFF to 0x00.
- R5: In a read, the block shifts out reg_rdata at the pointer, MSB first, and advances the pointer after each byte. It sends the next byte while the host acknowledges. After a host not-acknowledge it releases SDA until the next START.
- R6: A data byte 0x63 written to register 0x80 produces exactly one soft_rst pulse, one clock long, after that byte's acknowledge clock ends. The byte is still written to the register file. Any other value, or any other register, produces no pulse.
- R7: A STOP returns the block to idle with SDA released. A START or repeated START at any point, including in the middle of a byte, restarts address reception.
- R8: While rst is high and in the cycle after it, sda_oe, reg_we and soft_rst are 0 and reg_addr is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 2 | Address strap: 00 ground, 01 supply, 10 SDA, 11 SCL |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| reg_addr | output | 8 | Register pointer, also the register file address |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the register file at reg_addr, combinational |
| soft_rst | output | 1 | One-cycle soft-reset pulse for the rest of the device |

## Verification
The bench uses the default base address 0x5A, a two-stage synchroniser, and the default soft-reset register and key. It therefore reaches every strap setting and the exact 0x80/0x63 trigger with a few bus transactions. A bus half period of ten system clocks leaves room for the synchroniser and detection latency. With that margin, acknowledge timing, repeated START and a STOP in the middle of a byte can all be exercised without any race. Writes that wrap the pointer through 0xFF and bursts that cross register 0x80 cover the pointer arithmetic and the soft-reset match.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    localparam logic [DEV_W-1:0]  DEV_BASE_DEF = 7'h5A;
    localparam logic [BYTE_W-1:0] SRST_REG_DEF = 8'h80;
    localparam logic [BYTE_W-1:0] SRST_KEY_DEF = 8'h63;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic [DEV_W-1:0] strap_addr(input logic [DEV_W-1:0] base,
                                                    input logic [1:0] strap);
        return base + {{(DEV_W-2){1'b0}}, strap};
    endfunction

endpackage

// File: rtl/tgt_bus_sync.sv
module tgt_bus_sync
    import tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_q;
    logic [LAST:0] sda_q;
    logic          scl_p;
    logic          sda_p;
    logic          scl_s;
    logic          sda_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[LAST-1:0], scl_i};
                    sda_q <= {sda_q[LAST-1:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q[LAST];
            sda_p <= sda_q[LAST];
        end
    end

    assign scl_s = scl_q[LAST];
    assign sda_s = sda_q[LAST];

    always_comb begin
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/tgt_engine.sv
module tgt_engine
    import tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] ptr,
    output logic [BYTE_W-1:0] wdata,
    output logic              we,
    output logic              commit,
    output logic [BYTE_W-1:0] commit_addr
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e        state;
    rx_phase_e         phase;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              full;
    logic              rw;
    logic              host_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            phase       <= PH_DEV;
            shreg       <= '0;
            cnt         <= '0;
            full        <= 1'b0;
            rw          <= 1'b0;
            host_ack    <= 1'b0;
            sda_oe      <= 1'b0;
            ptr         <= '0;
            wdata       <= '0;
            we          <= 1'b0;
            commit      <= 1'b0;
            commit_addr <= '0;
        end else begin
            we     <= 1'b0;
            commit <= 1'b0;
            if (evt.start) begin
                state  <= ST_RX;
                phase  <= PH_DEV;
                cnt    <= '0;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (evt.scl_rise && !full) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                            full  <= (cnt == CNT_LAST);
                        end else if (evt.scl_fall && full) begin
                            full <= 1'b0;
                            case (phase)
                                PH_DEV: begin
                                    if (shreg[BYTE_W-1:1] == dev_addr) begin
                                        rw     <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end
                                PH_REG: begin
                                    ptr    <= shreg;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    wdata       <= shreg;
                                    commit_addr <= ptr;
                                    we          <= 1'b1;
                                    sda_oe      <= 1'b1;
                                    state       <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            case (phase)
                                PH_DEV: begin
                                    if (rw) begin
                                        shreg  <= rdata;
                                        ptr    <= ptr + 1'b1;
                                        sda_oe <= ~rdata[BYTE_W-1];
                                        state  <= ST_TX;
                                    end else begin
                                        phase <= PH_REG;
                                        state <= ST_RX;
                                    end
                                end
                                PH_REG: begin
                                    phase <= PH_DATA;
                                    state <= ST_RX;
                                end
                                default: begin
                                    commit <= 1'b1;
                                    ptr    <= ptr + 1'b1;
                                    state  <= ST_RX;
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise) begin
                            host_ack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (host_ack) begin
                                shreg  <= rdata;
                                ptr    <= ptr + 1'b1;
                                sda_oe <= ~rdata[BYTE_W-1];
                                cnt    <= '0;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tgt_softrst.sv
module tgt_softrst
    import tgt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] TRIG_REG = SRST_REG_DEF,
    parameter logic [BYTE_W-1:0] TRIG_KEY = SRST_KEY_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [BYTE_W-1:0] commit_addr,
    input  logic [BYTE_W-1:0] commit_data,
    output logic              pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= commit && (commit_addr == TRIG_REG) && (commit_data == TRIG_KEY);
        end
    end

endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
    import tgt_pkg::*;
#(
    parameter logic [DEV_W-1:0]  DEV_BASE    = DEV_BASE_DEF,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] SRST_REG    = SRST_REG_DEF,
    parameter logic [BYTE_W-1:0] SRST_KEY    = SRST_KEY_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              soft_rst
);
    bus_evt_t          evt;
    logic [DEV_W-1:0]  dev_addr;
    logic              commit;
    logic [BYTE_W-1:0] commit_addr;

    assign dev_addr = strap_addr(DEV_BASE, strap);

    tgt_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    tgt_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .dev_addr    (dev_addr),
        .rdata       (reg_rdata),
        .sda_oe      (sda_oe),
        .ptr         (reg_addr),
        .wdata       (reg_wdata),
        .we          (reg_we),
        .commit      (commit),
        .commit_addr (commit_addr)
    );

    tgt_softrst #(.TRIG_REG(SRST_REG), .TRIG_KEY(SRST_KEY)) u_srst (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (reg_wdata),
        .pulse       (soft_rst)
    );

endmodule

// File: rtl/tgt_checker.sv
module tgt_checker
    import tgt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SRST_REG = SRST_REG_DEF,
    parameter logic [BYTE_W-1:0] SRST_KEY = SRST_KEY_DEF
) (
    input logic              clk,
    input logic              rst,
    input bus_evt_t          evt,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [BYTE_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              soft_rst
);
    // R3: the SDA drive moves only on SCL fall, START or STOP
    assert_oe_on_event_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(evt.scl_fall || evt.start || evt.stop));

    // R4: every write is made while its byte is being acknowledged
    assert_we_in_ack_R4: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> sda_oe);

    // R4: write strobe lasts one cycle
    assert_we_single_R4: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R6: pulse only after the key landed in the trigger register
    assert_srst_match_R6: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (reg_wdata == SRST_KEY) && (reg_addr == SRST_REG + 8'd1));

    // R6: pulse lasts one cycle
    assert_srst_single_R6: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);

    // R8: outputs idle after a reset cycle
    assert_reset_idle_R8: assert property (@(posedge clk)
        rst |=> !sda_oe && !reg_we && !soft_rst && (reg_addr == 8'h00));

endmodule

bind strap_i2c_target tgt_checker #(.SRST_REG(SRST_REG), .SRST_KEY(SRST_KEY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .soft_rst  (soft_rst)
);

// File: tb/test_strap_i2c_target.sv
module test_strap_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int H = 10;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       soft_rst;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [15:0] exp_q[$];

    int nchk = 0;
    int nerr = 0;
    int srst_cnt = 0;
    bit done = 0;
    logic srst_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    strap_i2c_target i_strap_i2c_target (
        .clk       (clk),
        .rst       (rst),
        .strap     (strap),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .soft_rst  (soft_rst)
    );

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: R4 writes in order, R6 pulse width
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R4", "unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check({reg_addr, reg_wdata} == e, "R4", "write addr/data",
                      {reg_addr, reg_wdata}, e);
            end
        end
        if (!rst && soft_rst) begin
            srst_cnt++;
            if (srst_prev) check(1'b0, "R6", "pulse wider than one cycle", 2, 1);
        end
        srst_prev <= soft_rst;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H);
            scl_m = 1'b1; wt(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H/2);
        ack = ~sda_line;
        wt(H/2);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H);
            scl_m = 1'b1; wt(H/2);
            b[i] = sda_line;
            wt(H/2);
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(H);
        sda_m = 1'b1;
    endtask

    // driver: pushes expected writes into the scoreboard
    task automatic wr_burst(input logic [6:0] dev, input logic [7:0] ra,
                            input bq_t d, input string req);
        bit ack;
        logic [7:0] p;
        bus_start();
        send_byte({dev, 1'b0}, ack);
        check(ack, req, "address ack", ack, 1);
        send_byte(ra, ack);
        check(ack, "R3", "register byte ack", ack, 1);
        p = ra;
        foreach (d[k]) begin
            exp_q.push_back({p, d[k]});
            exp_mem[p] = d[k];
            send_byte(d[k], ack);
            check(ack, "R3", "data byte ack", ack, 1);
            p = p + 8'd1;
        end
        bus_stop();
        wt(H);
    endtask

    task automatic rd_burst(input logic [6:0] dev, input logic [7:0] ra, input int n);
        bit ack;
        logic [7:0] b;
        logic [7:0] p;
        bus_start();
        send_byte({dev, 1'b0}, ack);
        send_byte(ra, ack);
        bus_start();
        send_byte({dev, 1'b1}, ack);
        check(ack, "R5", "read address ack", ack, 1);
        p = ra;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(b == exp_mem[p], "R5", "read data", b, exp_mem[p]);
            p = p + 8'd1;
        end
        wt(4);
        check(sda_oe == 1'b0, "R5", "released after host nack", sda_oe, 0);
        bus_stop();
        wt(H);
    endtask

    initial begin
        bit ack;
        int c0;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5C;
            exp_mem[i] = 8'(i) ^ 8'h5C;
        end
        wt(5);
        // R8: outputs while held in reset
        check(!sda_oe && !reg_we && !soft_rst && reg_addr == 8'h00, "R8", "reset state",
              {sda_oe, reg_we, soft_rst}, 0);
        rst = 1'b0;
        wt(5);
        check(reg_addr == 8'h00 && !sda_oe, "R8", "after reset", reg_addr, 0);

        // R1 and R2: each strap answers only its own address
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            wt(4);
            wr_burst(7'h5A + 7'(s), 8'h10 + 8'(s), '{8'hA0 + 8'(s)}, "R1");
            bus_start();
            send_byte({7'h5A + 7'((s + 1) % 4), 1'b0}, ack);
            check(!ack, "R2", "foreign address nack", ack, 0);
            send_byte(8'h33, ack);
            check(!ack, "R2", "ignored byte nack", ack, 0);
            check(sda_oe == 1'b0, "R2", "sda released", sda_oe, 0);
            bus_stop();
            wt(H);
        end
        strap = 2'b00;
        wt(4);

        // R4: burst and pointer wrap
        wr_burst(7'h5A, 8'h20, '{8'h11, 8'h22, 8'h33, 8'h44}, "R4");
        wr_burst(7'h5A, 8'hFF, '{8'h9E, 8'h9F}, "R4");

        // R5: reads with repeated START, incl. across wrap
        rd_burst(7'h5A, 8'h20, 4);
        rd_burst(7'h5A, 8'hFE, 3);
        rd_burst(7'h5A, 8'h40, 2);

        // R6: key at trigger register, wrong key, wrong register, burst crossing
        c0 = srst_cnt;
        wr_burst(7'h5A, 8'h80, '{8'h63}, "R6");
        wt(4);
        check(srst_cnt == c0 + 1, "R6", "key pulse count", srst_cnt - c0, 1);
        c0 = srst_cnt;
        wr_burst(7'h5A, 8'h80, '{8'h62}, "R6");
        wr_burst(7'h5A, 8'h81, '{8'h63}, "R6");
        check(srst_cnt == c0, "R6", "no pulse for near misses", srst_cnt - c0, 0);
        c0 = srst_cnt;
        wr_burst(7'h5A, 8'h7F, '{8'h00, 8'h63, 8'h01}, "R6");
        check(srst_cnt == c0 + 1, "R6", "burst crossing trigger", srst_cnt - c0, 1);
        rd_burst(7'h5A, 8'h7F, 3);

        // R7: STOP in the middle of a byte, then normal traffic
        bus_start();
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b1; wt(H);
            scl_m = 1'b1; wt(H);
            scl_m = 1'b0;
        end
        bus_stop();
        wt(H);
        check(sda_oe == 1'b0, "R7", "idle after stop", sda_oe, 0);
        wr_burst(7'h5A, 8'h50, '{8'hC3}, "R7");

        // R7: repeated START after the register byte restarts reception
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        send_byte(8'h60, ack);
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        check(ack, "R7", "address after repeated start", ack, 1);
        send_byte(8'h61, ack);
        exp_q.push_back({8'h61, 8'h7E});
        exp_mem[8'h61] = 8'h7E;
        send_byte(8'h7E, ack);
        check(ack, "R7", "data after repeated start", ack, 1);
        bus_stop();
        wt(H);
        rd_burst(7'h5A, 8'h60, 2);

        check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule